// File: doc/BRIEF.md
# Multi-Source Reset and Wake Controller

This block turns a set of reset and wake-up requests into one reset sequence for the processor. Every request is mapped to one of three sequence types. A full reset comes from the power-on or brown-out detectors. A short reset comes from the external reset pin, the debugger's reset bit, or a watchdog expiry while the chip runs. A stop recovery comes from a watchdog expiry, an enabled GPIO wake edge, or the debug pin going low while the chip is in Stop mode. The types differ in two ways: how long they hold the processor, and which register groups they clear.

Each hold has two phases. The first counts cycles of the slow watchdog oscillator: 514 for full resets and stop recovery, 66 for short resets. The longer count gives an external crystal time to start. The first phase runs in the oscillator's own clock domain, and its completion crosses back to the system clock through a two-flop synchronizer. The second phase then counts 16 system-clock cycles.

During a sequence, a request of a higher type restarts the sequence with the new type. Requests of the same or a lower type are ignored. A sticky status output reports the type and the source of the most recent sequence, and it stays readable after the processor is released.

Top module: `reset_wake_ctrl`

## Requirements
- R1: A power-on or brown-out request, in either mode, starts a full reset: last_type = 3, with both ctrl_reg_rst and wdtctl_rst asserted for the whole hold.
- R2: While stop_mode is low, the following start a short reset (last_type = 1): pin_rst_n low, dbg_ctl_rst high, or wdt_timeout high with wdt_rst_en high. pin_rst_n and dbg_ctl_rst also start a short reset in Stop mode.
- R3: While stop_mode is high, the following start a stop recovery (last_type = 2): wdt_timeout, gpio_wake, or dbg_pin_n low. During a stop recovery wdtctl_rst is asserted and ctrl_reg_rst stays low.
- R4: Full reset and stop recovery hold cpu_rst for 514 watchdog-clock cycles followed by 16 system-clock cycles, plus synchronizer delay.
- R5: A short reset holds cpu_rst for 66 watchdog-clock cycles followed by 16 system-clock cycles, plus synchronizer delay.
- R6: A request of a higher type that arrives during a sequence restarts it with that type, and cpu_rst stays high throughout. The type ranking is full > recovery > short.
- R7: A request of an equal or lower type during a sequence changes neither its length nor the reported cause.
- R8: The following start no reset and leave last_cause unchanged: gpio_wake or dbg_pin_n low while running, or a running watchdog expiry with wdt_rst_en low.
- R9: last_cause is sticky. It is updated only when a sequence starts or restarts, and its codes are: 1 power-on, 2 brown-out, 3 pin, 4 debug bit, 5 watchdog while running, 6 watchdog in Stop, 7 GPIO wake, 8 debug pin.
- R10: Right after arst_n is released, the block is already in a full reset with cause 1, and cpu_rst is high.
- R11: ctrl_reg_rst and wdtctl_rst are asserted only while cpu_rst is high.
- R12: When several sources of the same type request together, the one with the lowest cause code is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| wdt_clk | input | 1 | Slow watchdog oscillator clock |
| arst_n | input | 1 | Asynchronous active-low reset of the block itself |
| por_req | input | 1 | Power-on detector request |
| bor_req | input | 1 | Brown-out detector request |
| pin_rst_n | input | 1 | External reset pin, active low |
| dbg_ctl_rst | input | 1 | Debugger reset control bit |
| wdt_timeout | input | 1 | Watchdog expiry |
| wdt_rst_en | input | 1 | Option: watchdog expiry resets while running |
| stop_mode | input | 1 | Chip is in Stop mode |
| gpio_wake | input | 1 | Enabled GPIO wake transition |
| dbg_pin_n | input | 1 | Debug pin, wake when low |
| cpu_rst | output | 1 | Processor held in reset |
| ctrl_reg_rst | output | 1 | Control-register reset |
| wdtctl_rst | output | 1 | Watchdog control register reset |
| last_type | output | 2 | Type of last sequence: 1 short, 2 recovery, 3 full |
| last_cause | output | 4 | Source code of last sequence |

## Verification
The hardest case to reach is a restart: the bench has to place a second, higher-ranked request inside the slow-oscillator phase of a sequence that is already running. To do this, the bench asserts the second source a fixed number of system cycles after the first one, well before the 66- or 514-count phase can finish. It then checks that the total hold equals the pre-restart time plus a complete new latency. The reverse case, a lower-ranked request during a full reset, is timed the same way. Random single and paired sources in both modes exercise the same-type ordering.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  typedef enum logic [1:0] {
    RT_NONE  = 2'd0,
    RT_SHORT = 2'd1,
    RT_RECOV = 2'd2,
    RT_FULL  = 2'd3
  } rst_type_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_SLOW,
    ST_FAST
  } seq_state_e;

  localparam int unsigned CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CZ_NONE   = 4'd0;
  localparam logic [CAUSE_W-1:0] CZ_POR    = 4'd1;
  localparam logic [CAUSE_W-1:0] CZ_BOR    = 4'd2;
  localparam logic [CAUSE_W-1:0] CZ_PIN    = 4'd3;
  localparam logic [CAUSE_W-1:0] CZ_DBGBIT = 4'd4;
  localparam logic [CAUSE_W-1:0] CZ_WDTRUN = 4'd5;
  localparam logic [CAUSE_W-1:0] CZ_WDTSTP = 4'd6;
  localparam logic [CAUSE_W-1:0] CZ_GPIO   = 4'd7;
  localparam logic [CAUSE_W-1:0] CZ_DBGPIN = 4'd8;

  localparam int unsigned RQ_POR    = 0;
  localparam int unsigned RQ_BOR    = 1;
  localparam int unsigned RQ_PIN    = 2;
  localparam int unsigned RQ_DBGBIT = 3;
  localparam int unsigned RQ_WDT    = 4;
  localparam int unsigned RQ_WDTEN  = 5;
  localparam int unsigned RQ_STOP   = 6;
  localparam int unsigned RQ_GPIO   = 7;
  localparam int unsigned RQ_DBGPIN = 8;
  localparam int unsigned RQ_W      = 9;
endpackage

// File: rtl/rwc_rst_sync.sv
module rwc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic meta_q, hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n = hold_q;
endmodule

// File: rtl/rwc_sync.sv
module rwc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rwc_slow_cnt.sv
module rwc_slow_cnt #(
  parameter int unsigned LONG_CYC    = 514,
  parameter int unsigned SHORT_CYC   = 66,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic wclk,
  input  logic wrst_n,
  input  logic go_async,
  input  logic long_sel,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(LONG_CYC + 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);

  logic             go_s;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] last_v;

  rwc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_go_sync (
    .clk(wclk), .rst_n(wrst_n), .d(go_async), .q(go_s)
  );

  assign last_v = long_sel ? LONG_LAST : SHORT_LAST;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!go_s) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == last_v) done_d = 1'b1;
      else                 cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy = go_s;
  assign done = done_q;
endmodule

// File: rtl/reset_wake_ctrl.sv
module reset_wake_ctrl
  import rwc_pkg::*;
#(
  parameter int unsigned LONG_SLOW   = 514,
  parameter int unsigned SHORT_SLOW  = 66,
  parameter int unsigned FAST_CYC    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         sys_clk,
  input  logic         wdt_clk,
  input  logic         arst_n,
  input  logic         por_req,
  input  logic         bor_req,
  input  logic         pin_rst_n,
  input  logic         dbg_ctl_rst,
  input  logic         wdt_timeout,
  input  logic         wdt_rst_en,
  input  logic         stop_mode,
  input  logic         gpio_wake,
  input  logic         dbg_pin_n,
  output logic         cpu_rst,
  output logic         ctrl_reg_rst,
  output logic         wdtctl_rst,
  output logic [1:0]   last_type,
  output logic [3:0]   last_cause
);
  localparam int unsigned FC_W = (FAST_CYC > 1) ? $clog2(FAST_CYC) : 1;
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(FAST_CYC - 1);

  logic srst_n, wrst_n;
  logic [RQ_W-1:0] raw_req, req_s;
  logic [1:0] hs_s;
  logic slow_busy, slow_done;

  seq_state_e        state_q, state_d;
  rst_type_e         type_q, type_d, new_type;
  logic [CAUSE_W-1:0] cause_q, cause_d, new_cause;
  logic [FC_W-1:0]   fcnt_q, fcnt_d;
  logic              go_q, long_q;

  rwc_rst_sync u_srst (.clk(sys_clk), .arst_n(arst_n), .rst_n(srst_n));
  rwc_rst_sync u_wrst (.clk(wdt_clk), .arst_n(arst_n), .rst_n(wrst_n));

  always_comb begin
    raw_req            = '0;
    raw_req[RQ_POR]    = por_req;
    raw_req[RQ_BOR]    = bor_req;
    raw_req[RQ_PIN]    = ~pin_rst_n;
    raw_req[RQ_DBGBIT] = dbg_ctl_rst;
    raw_req[RQ_WDT]    = wdt_timeout;
    raw_req[RQ_WDTEN]  = wdt_rst_en;
    raw_req[RQ_STOP]   = stop_mode;
    raw_req[RQ_GPIO]   = gpio_wake;
    raw_req[RQ_DBGPIN] = ~dbg_pin_n;
  end

  rwc_sync #(.W(RQ_W), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(sys_clk), .rst_n(srst_n), .d(raw_req), .q(req_s)
  );

  // Classify: highest type wins, lowest cause code inside a type
  always_comb begin
    new_type  = RT_NONE;
    new_cause = CZ_NONE;
    if (req_s[RQ_POR]) begin
      new_type = RT_FULL;  new_cause = CZ_POR;
    end else if (req_s[RQ_BOR]) begin
      new_type = RT_FULL;  new_cause = CZ_BOR;
    end else if (req_s[RQ_STOP] && req_s[RQ_WDT]) begin
      new_type = RT_RECOV; new_cause = CZ_WDTSTP;
    end else if (req_s[RQ_STOP] && req_s[RQ_GPIO]) begin
      new_type = RT_RECOV; new_cause = CZ_GPIO;
    end else if (req_s[RQ_STOP] && req_s[RQ_DBGPIN]) begin
      new_type = RT_RECOV; new_cause = CZ_DBGPIN;
    end else if (req_s[RQ_PIN]) begin
      new_type = RT_SHORT; new_cause = CZ_PIN;
    end else if (req_s[RQ_DBGBIT]) begin
      new_type = RT_SHORT; new_cause = CZ_DBGBIT;
    end else if (!req_s[RQ_STOP] && req_s[RQ_WDT] && req_s[RQ_WDTEN]) begin
      new_type = RT_SHORT; new_cause = CZ_WDTRUN;
    end
  end

  rwc_slow_cnt #(
    .LONG_CYC(LONG_SLOW), .SHORT_CYC(SHORT_SLOW), .SYNC_STAGES(SYNC_STAGES)
  ) u_slow (
    .wclk(wdt_clk), .wrst_n(wrst_n), .go_async(go_q), .long_sel(long_q),
    .busy(slow_busy), .done(slow_done)
  );

  rwc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_hs_sync (
    .clk(sys_clk), .rst_n(srst_n), .d({slow_busy, slow_done}), .q(hs_s)
  );

  always_comb begin
    state_d = state_q;
    type_d  = type_q;
    cause_d = cause_q;
    fcnt_d  = fcnt_q;
    unique case (state_q)
      ST_IDLE: if (new_type != RT_NONE) begin
        state_d = ST_DRAIN; type_d = new_type; cause_d = new_cause;
      end
      ST_DRAIN: if (hs_s == 2'b00) state_d = ST_SLOW;
      ST_SLOW: if (hs_s[0]) begin
        state_d = ST_FAST; fcnt_d = '0;
      end
      ST_FAST: begin
        if (fcnt_q == FC_LAST) begin
          if (new_type != RT_NONE) begin
            state_d = ST_DRAIN; type_d = new_type; cause_d = new_cause;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          fcnt_d = fcnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_q != ST_IDLE && new_type > type_q) begin
      state_d = ST_DRAIN; type_d = new_type; cause_d = new_cause;
    end
  end

  always_ff @(posedge sys_clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_DRAIN;
      type_q  <= RT_FULL;
      cause_q <= CZ_POR;
      fcnt_q  <= '0;
      go_q    <= 1'b0;
      long_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      type_q  <= type_d;
      cause_q <= cause_d;
      fcnt_q  <= fcnt_d;
      go_q    <= (state_d == ST_SLOW);
      long_q  <= (type_d != RT_SHORT);
    end
  end

  assign cpu_rst      = (state_q != ST_IDLE);
  assign ctrl_reg_rst = cpu_rst && (type_q != RT_RECOV);
  assign wdtctl_rst   = cpu_rst;
  assign last_type    = type_q;
  assign last_cause   = cause_q;
endmodule

// File: rtl/reset_wake_ctrl_chk.sv
module reset_wake_ctrl_chk #(
  parameter int unsigned FAST_CYC = 16
) (
  input logic       sys_clk,
  input logic       arst_n,
  input logic       cpu_rst,
  input logic       ctrl_reg_rst,
  input logic       wdtctl_rst,
  input logic [1:0] last_type,
  input logic [3:0] last_cause
);
  logic [7:0] hold_q;

  always_ff @(posedge sys_clk or negedge arst_n) begin
    if (!arst_n)              hold_q <= '0;
    else if (!cpu_rst)        hold_q <= '0;
    else if (hold_q != 8'hFF) hold_q <= hold_q + 8'd1;
  end

  // R11
  ctrl_in_cpu_chk: assert property (@(posedge sys_clk) disable iff (!arst_n)
    ctrl_reg_rst |-> cpu_rst);
  // R11
  ctrl_in_wdtctl_chk: assert property (@(posedge sys_clk) disable iff (!arst_n)
    ctrl_reg_rst |-> wdtctl_rst);
  // R3
  recov_keeps_ctrl_chk: assert property (@(posedge sys_clk) disable iff (!arst_n)
    (cpu_rst && last_type == 2'd2) |-> !ctrl_reg_rst);
  // R1
  full_clears_ctrl_chk: assert property (@(posedge sys_clk) disable iff (!arst_n)
    (cpu_rst && last_type == 2'd3) |-> ctrl_reg_rst);
  // R9
  cause_sticky_chk: assert property (@(posedge sys_clk) disable iff (!arst_n)
    (!cpu_rst ##1 !cpu_rst) |-> $stable(last_cause));
  // R9
  cause_set_chk: assert property (@(posedge sys_clk) disable iff (!arst_n)
    $rose(cpu_rst) |-> (last_cause != 4'd0));
  // R4
  hold_min_chk: assert property (@(posedge sys_clk) disable iff (!arst_n)
    $fell(cpu_rst) |-> (hold_q >= 8'(FAST_CYC)));
endmodule

bind reset_wake_ctrl reset_wake_ctrl_chk #(.FAST_CYC(FAST_CYC)) u_chk (
  .sys_clk(sys_clk), .arst_n(arst_n), .cpu_rst(cpu_rst),
  .ctrl_reg_rst(ctrl_reg_rst), .wdtctl_rst(wdtctl_rst),
  .last_type(last_type), .last_cause(last_cause)
);

// File: tb/test_reset_wake_ctrl.sv
module test_reset_wake_ctrl;
  localparam int LONG_N = 514;
  localparam int SHORT_N = 66;
  localparam int FAST_N = 16;
  localparam int RATIO = 3;
  localparam int SLACK = 40;

  logic sys_clk = 1'b0;
  logic wdt_clk = 1'b0;
  logic arst_n;
  logic por_req, bor_req, pin_rst_n, dbg_ctl_rst, wdt_timeout, wdt_rst_en;
  logic stop_mode, gpio_wake, dbg_pin_n;
  logic cpu_rst, ctrl_reg_rst, wdtctl_rst;
  logic [1:0] last_type;
  logic [3:0] last_cause;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int seed_v;

  always #2 sys_clk = ~sys_clk;
  always #6 wdt_clk = ~wdt_clk;
  always @(posedge sys_clk) cyc++;

  reset_wake_ctrl i_reset_wake_ctrl (
    .sys_clk(sys_clk), .wdt_clk(wdt_clk), .arst_n(arst_n),
    .por_req(por_req), .bor_req(bor_req), .pin_rst_n(pin_rst_n),
    .dbg_ctl_rst(dbg_ctl_rst), .wdt_timeout(wdt_timeout), .wdt_rst_en(wdt_rst_en),
    .stop_mode(stop_mode), .gpio_wake(gpio_wake), .dbg_pin_n(dbg_pin_n),
    .cpu_rst(cpu_rst), .ctrl_reg_rst(ctrl_reg_rst), .wdtctl_rst(wdtctl_rst),
    .last_type(last_type), .last_cause(last_cause)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // source bits: 0 por, 1 bor, 2 pin, 3 dbg bit, 4 wdt, 5 gpio, 6 dbg pin
  function automatic int exp_code(input logic [6:0] s, input bit stop, input bit opt);
    if (s[0]) return 1;
    if (s[1]) return 2;
    if (stop && s[4]) return 6;
    if (stop && s[5]) return 7;
    if (stop && s[6]) return 8;
    if (s[2]) return 3;
    if (s[3]) return 4;
    if (!stop && s[4] && opt) return 5;
    return 0;
  endfunction

  function automatic int exp_type(input int code);
    if (code == 1 || code == 2) return 3;
    if (code >= 6) return 2;
    if (code >= 3) return 1;
    return 0;
  endfunction

  function automatic int base_len(input int t);
    return ((t == 1) ? SHORT_N : LONG_N) * RATIO + FAST_N;
  endfunction

  task automatic set_src(input logic [6:0] s);
    por_req     = s[0];
    bor_req     = s[1];
    pin_rst_n   = ~s[2];
    dbg_ctl_rst = s[3];
    wdt_timeout = s[4];
    gpio_wake   = s[5];
    dbg_pin_n   = ~s[6];
  endtask

  task automatic run_case(input logic [6:0] s1, input bit stop, input bit opt,
                          input logic [6:0] s2, input int k, input string tag);
    int dur = 0;
    int t = 0;
    bit saw_ctrl = 1'b0;
    bit saw_w = 1'b0;
    int prev_cause = int'(last_cause);
    int e1 = exp_code(s1, stop, opt);
    int e2 = exp_code(s2, stop, opt);
    int ef, tf, lo, hi;
    if (k > 0 && exp_type(e2) > exp_type(e1)) begin
      ef = e2; tf = exp_type(e2);
      lo = k + base_len(tf) - 5; hi = k + base_len(tf) + SLACK;
    end else begin
      ef = e1; tf = exp_type(e1);
      lo = base_len(tf); hi = base_len(tf) + SLACK;
    end
    @(negedge sys_clk);
    stop_mode = stop; wdt_rst_en = opt; set_src(s1);
    while (t < 4000) begin
      @(negedge sys_clk);
      t++;
      if (t == 8) set_src(7'd0);
      if (k > 0 && t == k) set_src(s2);
      if (k > 0 && t == k + 8) set_src(7'd0);
      if (cpu_rst) dur++;
      if (ctrl_reg_rst) saw_ctrl = 1'b1;
      if (wdtctl_rst) saw_w = 1'b1;
      if (dur > 0 && !cpu_rst && t > k + 8) break;
      if (tf == 0 && t >= 60) break;
    end
    if (tf == 0) begin
      chk(dur == 0, {"R8 no reset ", tag}, dur, 0);
      chk(int'(last_cause) == prev_cause, {"R8 R9 cause kept ", tag}, int'(last_cause), prev_cause);
    end else begin
      chk(int'(last_cause) == ef, {"R9 R12 cause ", tag}, int'(last_cause), ef);
      chk(int'(last_type) == tf, {"R1 R2 R3 type ", tag}, int'(last_type), tf);
      chk(dur >= lo && dur <= hi, {"R4 R5 hold length ", tag}, dur, lo);
      chk(saw_ctrl == (tf != 2), {"R1 R3 ctrl scope ", tag}, int'(saw_ctrl), int'(tf != 2));
      chk(saw_w, {"R11 wdtctl reset ", tag}, int'(saw_w), 1);
    end
    @(negedge sys_clk);
    stop_mode = 1'b0;
    repeat (5) @(negedge sys_clk);
  endtask

  initial begin
    while (cyc < 190000) @(posedge sys_clk);
    n_fail++;
    $display("FAIL watchdog R4: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    int dur;
    seed_v = $urandom(32'd4021);
    arst_n = 1'b0;
    stop_mode = 1'b0;
    wdt_rst_en = 1'b0;
    set_src(7'd0);
    repeat (5) @(negedge sys_clk);
    arst_n = 1'b1;
    @(negedge sys_clk);
    // R10 reset state
    chk(cpu_rst == 1'b1, "R10 cpu_rst after reset", int'(cpu_rst), 1);
    chk(int'(last_cause) == 1, "R10 cause after reset", int'(last_cause), 1);
    chk(int'(last_type) == 3, "R10 type after reset", int'(last_type), 3);
    chk(ctrl_reg_rst == 1'b1, "R10 R1 ctrl after reset", int'(ctrl_reg_rst), 1);
    dur = 1;
    while (cpu_rst && dur < 4000) begin
      @(negedge sys_clk);
      dur++;
    end
    chk(dur >= base_len(3) && dur <= base_len(3) + SLACK, "R10 R4 power-up hold", dur, base_len(3));
    repeat (5) @(negedge sys_clk);

    run_case(7'b0000001, 1'b0, 1'b0, 7'd0, 0, "R1 por run");
    run_case(7'b0000010, 1'b1, 1'b0, 7'd0, 0, "R1 bor stop");
    run_case(7'b0000100, 1'b0, 1'b0, 7'd0, 0, "R2 pin");
    run_case(7'b0001000, 1'b0, 1'b0, 7'd0, 0, "R2 dbg bit");
    run_case(7'b0010000, 1'b0, 1'b1, 7'd0, 0, "R2 wdt run");
    run_case(7'b0000100, 1'b1, 1'b0, 7'd0, 0, "R2 pin in stop");
    run_case(7'b0010000, 1'b1, 1'b0, 7'd0, 0, "R3 wdt stop");
    run_case(7'b0100000, 1'b1, 1'b0, 7'd0, 0, "R3 gpio");
    run_case(7'b1000000, 1'b1, 1'b0, 7'd0, 0, "R3 dbg pin");
    run_case(7'b0100000, 1'b0, 1'b0, 7'd0, 0, "R8 gpio run");
    run_case(7'b0010000, 1'b0, 1'b0, 7'd0, 0, "R8 wdt no opt");
    run_case(7'b1000000, 1'b0, 1'b0, 7'd0, 0, "R8 dbg pin run");
    run_case(7'b0000100, 1'b0, 1'b0, 7'b0000001, 100, "R6 short to full");
    run_case(7'b0100000, 1'b1, 1'b0, 7'b0000010, 150, "R6 recov to full");
    run_case(7'b0000001, 1'b0, 1'b0, 7'b0000100, 200, "R7 pin during full");
    run_case(7'b0001100, 1'b0, 1'b0, 7'd0, 0, "R12 pin and dbg bit");
    run_case(7'b1100000, 1'b1, 1'b0, 7'd0, 0, "R12 gpio and dbg pin");

    for (int i = 0; i < 14; i++) begin
      logic [6:0] s;
      bit st, op;
      s = 7'(1 << ($urandom % 7));
      if ($urandom % 3 == 0) s = s | 7'(1 << ($urandom % 7));
      st = 1'($urandom % 2);
      op = 1'($urandom % 2);
      run_case(s, st, op, 7'd0, 0, "R1 R2 R3 R8 R12 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule